// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer with Access Rights

This block is a small fully associative buffer that turns virtual addresses into physical addresses for 8 KB pages. Each lookup presents a virtual address and says whether the access is a load or a store. The virtual page number is compared against every stored entry in parallel. The result is registered and appears one clock later as exactly one of three outcomes:
- a hit, with the translated physical address;
- a rights fault, when the entry forbids the access;
- a miss request, carrying the page number that was not found.

An external table walker answers a miss by presenting a refill entry. The block picks the slot itself. Empty slots are used first, lowest index first. When every slot is occupied, the slot comes from a free-running pseudo-random sequence, steered away from the slot that was used most recently. A flush input empties the buffer in a single cycle.

Top module: `xlat_cache`

## Requirements
- R1: A lookup accepted on a clock edge produces its result on the next edge, with exactly one of `hit`, `fault`, `miss_req` high for that one cycle. None of the three is high in a cycle that follows an edge without a lookup.
- R2: On a hit, `paddr` is the stored 21-bit physical page number in bits 33:13, followed by bits 12:0 of the virtual address unchanged. `paddr` is zero when `hit` is low.
- R3: On a miss, `miss_req` pulses and `miss_vpn` carries bits 42:13 of the looked-up virtual address. `miss_vpn` holds that value until the next miss.
- R4: A load (`lk_write`=0) to an entry whose read right is 0 gives `fault`=1 and `hit`=0. The same holds for a store (`lk_write`=1) to an entry whose write right is 0. The permitted access to the same entry still hits.
- R5: A refill goes to the lowest-indexed empty slot while one exists, so refilling 32 distinct pages into an empty buffer evicts nothing.
- R6: When the buffer is full, a refill replaces exactly one resident entry, and never the entry used last. The entry used last is the one that matched the latest lookup or received the latest refill.
- R7: `flush` invalidates every entry on the next edge. A refill presented in the same cycle as `flush` is discarded.
- R8: When two valid entries hold the same virtual page, the lower-indexed one supplies the translation and the rights.
- R9: After reset the buffer is empty and `hit`, `fault`, `miss_req` and `paddr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | 43 | Virtual address to translate |
| lk_write | input | 1 | 1 = store, 0 = load |
| fill_valid | input | 1 | Refill entry present this cycle |
| fill_vpn | input | 30 | Refill virtual page number |
| fill_ppn | input | 21 | Refill physical page number |
| fill_rd_ok | input | 1 | Refill read right |
| fill_wr_ok | input | 1 | Refill write right |
| hit | output | 1 | Translation succeeded |
| fault | output | 1 | Entry matched but access not permitted |
| paddr | output | 34 | Physical address on hit |
| miss_req | output | 1 | No entry matched; request to walker |
| miss_vpn | output | 30 | Page number to walk |

## Verification
Every outcome of a lookup is registered once, so it is due on the first rising edge after the edge that accepted the request. A refill or flush changes the contents on the edge where it is presented. The tasks drive a request on a falling edge and then wait one full clock. They sample `hit`, `fault`, `paddr` and `miss_req` on the following falling edge, half a period after the edge that loaded them. Replacement is checked through lookups alone: after each refill into a full buffer, every previously resident page is probed, and the bench requires exactly one miss and requires the page touched just before the refill to survive.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

   typedef enum logic [1:0] {
      RES_NONE  = 2'd0,
      RES_HIT   = 2'd1,
      RES_FAULT = 2'd2,
      RES_MISS  = 2'd3
   } xlat_res_e;

   // Galois feedback mask for a maximal-length sequence of the given width
   function automatic logic [15:0] lfsr_mask(input int width);
      case (width)
         8:       return 16'h00B8;
         default: return 16'hB400;
      endcase
   endfunction

endpackage

// File: rtl/xlat_cam.sv
module xlat_cam #(
   parameter int ENTRIES = 32,
   parameter int VPN_W   = 30,
   parameter int PPN_W   = 21,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [VPN_W-1:0]   wr_vpn,
   input  logic [PPN_W-1:0]   wr_ppn,
   input  logic               wr_rd,
   input  logic               wr_wr,
   input  logic [VPN_W-1:0]   lk_vpn,
   output logic               match_any,
   output logic [IDX_W-1:0]   match_idx,
   output logic [PPN_W-1:0]   match_ppn,
   output logic               match_rd,
   output logic               match_wr,
   output logic [ENTRIES-1:0] valid_vec
);

   logic [VPN_W-1:0] tag_q  [ENTRIES];
   logic [PPN_W-1:0] ppn_q  [ENTRIES];
   logic             rd_q   [ENTRIES];
   logic             wr_q   [ENTRIES];
   logic [ENTRIES-1:0] hit_vec;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_vec[g] <= 1'b0;
         end else if (flush) begin
            valid_vec[g] <= 1'b0;
         end else if (wr_en && wr_idx == IDX_W'(g)) begin
            valid_vec[g] <= 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (wr_en && wr_idx == IDX_W'(g)) begin
            tag_q[g] <= wr_vpn;
            ppn_q[g] <= wr_ppn;
            rd_q[g]  <= wr_rd;
            wr_q[g]  <= wr_wr;
         end
      end

      assign hit_vec[g] = valid_vec[g] && (tag_q[g] == lk_vpn);
   end

   // lowest index wins among multiple matches
   always_comb begin
      match_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (hit_vec[i]) match_idx = IDX_W'(i);
      end
   end

   assign match_any = |hit_vec;
   assign match_ppn = ppn_q[match_idx];
   assign match_rd  = rd_q[match_idx];
   assign match_wr  = wr_q[match_idx];

endmodule

// File: rtl/xlat_victim.sv
module xlat_victim
   import xlat_pkg::*;
#(
   parameter int ENTRIES = 32,
   parameter int LFSR_W  = 8,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ENTRIES-1:0] valid_vec,
   input  logic [IDX_W-1:0]   last_idx,
   output logic [IDX_W-1:0]   victim_idx,
   output logic               all_valid
);

   localparam logic [LFSR_W-1:0] MASK = LFSR_W'(lfsr_mask(LFSR_W));

   logic [LFSR_W-1:0] lfsr_q;
   logic [IDX_W-1:0]  free_idx;
   logic [IDX_W-1:0]  rnd_idx;

   if (LFSR_W != 8 && LFSR_W != 16) begin : g_bad_lfsr
      $error("xlat_victim: LFSR_W must be 8 or 16");
   end
   if (LFSR_W < IDX_W) begin : g_short_lfsr
      $error("xlat_victim: LFSR_W narrower than slot index");
   end

   // free-running Galois LFSR, shifts every clock
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lfsr_q <= LFSR_W'(1);
      else if (lfsr_q[0]) lfsr_q <= (lfsr_q >> 1) ^ MASK;
      else lfsr_q <= lfsr_q >> 1;
   end

   always_comb begin
      free_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (!valid_vec[i]) free_idx = IDX_W'(i);
      end
   end

   assign all_valid = &valid_vec;
   // step past the most recently used slot (wraps, ENTRIES is a power of two)
   assign rnd_idx    = (lfsr_q[IDX_W-1:0] == last_idx) ? lfsr_q[IDX_W-1:0] + 1'b1
                                                       : lfsr_q[IDX_W-1:0];
   assign victim_idx = all_valid ? rnd_idx : free_idx;

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
   import xlat_pkg::*;
#(
   parameter int ENTRIES = 32,
   parameter int VA_W    = 43,
   parameter int PA_W    = 34,
   parameter int OFF_W   = 13,
   parameter int LFSR_W  = 8,
   localparam int VPN_W  = VA_W - OFF_W,
   localparam int PPN_W  = PA_W - OFF_W,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             lk_valid,
   input  logic [VA_W-1:0]  lk_vaddr,
   input  logic             lk_write,
   input  logic             fill_valid,
   input  logic [VPN_W-1:0] fill_vpn,
   input  logic [PPN_W-1:0] fill_ppn,
   input  logic             fill_rd_ok,
   input  logic             fill_wr_ok,
   output logic             hit,
   output logic             fault,
   output logic [PA_W-1:0]  paddr,
   output logic             miss_req,
   output logic [VPN_W-1:0] miss_vpn
);

   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
      $error("xlat_cache: ENTRIES must be a power of two, at least 2");
   end
   if (OFF_W >= VA_W || OFF_W >= PA_W) begin : g_bad_offset
      $error("xlat_cache: page offset wider than an address");
   end

   logic [VPN_W-1:0]   lk_vpn;
   logic [OFF_W-1:0]   lk_off;
   logic               match_any;
   logic [IDX_W-1:0]   match_idx;
   logic [PPN_W-1:0]   match_ppn;
   logic               match_rd;
   logic               match_wr;
   logic [ENTRIES-1:0] valid_vec;
   logic [IDX_W-1:0]   victim_idx;
   logic               all_valid;
   logic [IDX_W-1:0]   last_idx;
   logic               fill_en;
   xlat_res_e          res;

   assign lk_vpn  = lk_vaddr[VA_W-1:OFF_W];
   assign lk_off  = lk_vaddr[OFF_W-1:0];
   assign fill_en = fill_valid && !flush;

   xlat_cam #(
      .ENTRIES (ENTRIES),
      .VPN_W   (VPN_W),
      .PPN_W   (PPN_W)
   ) cam_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .wr_en     (fill_en),
      .wr_idx    (victim_idx),
      .wr_vpn    (fill_vpn),
      .wr_ppn    (fill_ppn),
      .wr_rd     (fill_rd_ok),
      .wr_wr     (fill_wr_ok),
      .lk_vpn    (lk_vpn),
      .match_any (match_any),
      .match_idx (match_idx),
      .match_ppn (match_ppn),
      .match_rd  (match_rd),
      .match_wr  (match_wr),
      .valid_vec (valid_vec)
   );

   xlat_victim #(
      .ENTRIES (ENTRIES),
      .LFSR_W  (LFSR_W)
   ) victim_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .valid_vec  (valid_vec),
      .last_idx   (last_idx),
      .victim_idx (victim_idx),
      .all_valid  (all_valid)
   );

   // most recently used slot: a refill counts over a same-cycle lookup
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_idx <= '0;
      else if (fill_en) last_idx <= victim_idx;
      else if (lk_valid && match_any) last_idx <= match_idx;
   end

   always_comb begin
      res = RES_NONE;
      if (lk_valid) begin
         if (!match_any) res = RES_MISS;
         else if (lk_write ? match_wr : match_rd) res = RES_HIT;
         else res = RES_FAULT;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit      <= 1'b0;
         fault    <= 1'b0;
         miss_req <= 1'b0;
         paddr    <= '0;
         miss_vpn <= '0;
      end else begin
         hit      <= (res == RES_HIT);
         fault    <= (res == RES_FAULT);
         miss_req <= (res == RES_MISS);
         paddr    <= (res == RES_HIT) ? {match_ppn, lk_off} : '0;
         if (res == RES_MISS) miss_vpn <= lk_vpn;
      end
   end

endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
   parameter int ENTRIES = 32,
   parameter int VA_W    = 43,
   parameter int PA_W    = 34,
   parameter int OFF_W   = 13,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               flush,
   input logic               lk_valid,
   input logic [VA_W-1:0]    lk_vaddr,
   input logic               fill_valid,
   input logic               hit,
   input logic               fault,
   input logic               miss_req,
   input logic [PA_W-1:0]    paddr,
   input logic [VA_W-OFF_W-1:0] miss_vpn,
   input logic [ENTRIES-1:0] valid_vec,
   input logic [IDX_W-1:0]   victim_idx,
   input logic [IDX_W-1:0]   last_idx,
   input logic               all_valid
);

   a_r1_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> $countones({hit, fault, miss_req}) == 1);

   a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !(hit || fault || miss_req));

   a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> (!hit || paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0])));

   a_r3_miss_page: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> (!miss_req || miss_vpn == $past(lk_vaddr[VA_W-1:OFF_W])));

   a_r6_spare_recent: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_valid && !flush && all_valid) |-> victim_idx != last_idx);

   a_r7_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> valid_vec == '0);

endmodule

bind xlat_cache xlat_cache_chk #(
   .ENTRIES (ENTRIES),
   .VA_W    (VA_W),
   .PA_W    (PA_W),
   .OFF_W   (OFF_W)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .flush      (flush),
   .lk_valid   (lk_valid),
   .lk_vaddr   (lk_vaddr),
   .fill_valid (fill_valid),
   .hit        (hit),
   .fault      (fault),
   .miss_req   (miss_req),
   .paddr      (paddr),
   .miss_vpn   (miss_vpn),
   .valid_vec  (valid_vec),
   .victim_idx (victim_idx),
   .last_idx   (last_idx),
   .all_valid  (all_valid)
);

// File: tb/xlat_cache_tb.sv
module xlat_cache_tb_top;

   localparam int N     = 32;
   localparam int VA_W  = 43;
   localparam int PA_W  = 34;
   localparam int OFF_W = 13;
   localparam int VPN_W = VA_W - OFF_W;
   localparam int PPN_W = PA_W - OFF_W;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             flush = 1'b0;
   logic             lk_valid = 1'b0;
   logic [VA_W-1:0]  lk_vaddr = '0;
   logic             lk_write = 1'b0;
   logic             fill_valid = 1'b0;
   logic [VPN_W-1:0] fill_vpn = '0;
   logic [PPN_W-1:0] fill_ppn = '0;
   logic             fill_rd_ok = 1'b0;
   logic             fill_wr_ok = 1'b0;
   logic             hit, fault, miss_req;
   logic [PA_W-1:0]  paddr;
   logic [VPN_W-1:0] miss_vpn;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic             o_hit, o_fault, o_miss;
   logic [PA_W-1:0]  o_pa;
   logic [VPN_W-1:0] o_mvpn;

   always #2 clk = ~clk;

   xlat_cache dut_i (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_write(lk_write),
      .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
      .fill_rd_ok(fill_rd_ok), .fill_wr_ok(fill_wr_ok),
      .hit(hit), .fault(fault), .paddr(paddr),
      .miss_req(miss_req), .miss_vpn(miss_vpn)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_fill(input logic [VPN_W-1:0] vpn, input logic [PPN_W-1:0] ppn,
                          input logic rd, input logic wr, input logic with_flush);
      @(negedge clk);
      fill_valid = 1'b1; fill_vpn = vpn; fill_ppn = ppn;
      fill_rd_ok = rd; fill_wr_ok = wr; flush = with_flush;
      @(negedge clk);
      fill_valid = 1'b0; flush = 1'b0;
   endtask

   task automatic do_look(input logic [VPN_W-1:0] vpn, input logic [OFF_W-1:0] off,
                          input logic wr);
      @(negedge clk);
      lk_valid = 1'b1; lk_vaddr = {vpn, off}; lk_write = wr;
      @(negedge clk);
      lk_valid = 1'b0;
      o_hit = hit; o_fault = fault; o_miss = miss_req; o_pa = paddr; o_mvpn = miss_vpn;
   endtask

   task automatic t_reset();
      check("R9 hit after reset", 64'(hit), 0);
      check("R9 fault after reset", 64'(fault), 0);
      check("R9 miss after reset", 64'(miss_req), 0);
      check("R9 paddr after reset", 64'(paddr), 0);
      do_look(30'h0, 13'h0, 1'b0);
      check("R9 empty buffer misses", 64'(o_miss), 1);
   endtask

   task automatic t_basic();
      do_fill(30'h2345_6789, 21'h1A_BCDE, 1'b1, 1'b1, 1'b0);
      do_look(30'h2345_6789, 13'h1FFF, 1'b0);
      check("R1 hit flag", 64'(o_hit), 1);
      check("R1 single outcome", 64'({o_fault, o_miss}), 0);
      check("R2 paddr", 64'(o_pa), 64'({21'h1A_BCDE, 13'h1FFF}));
      do_look(30'h2345_6789, 13'h0A5, 1'b1);
      check("R2 paddr store", 64'(o_pa), 64'({21'h1A_BCDE, 13'h0A5}));
      @(negedge clk);
      check("R1 idle no outcome", 64'({hit, fault, miss_req}), 0);
   endtask

   task automatic t_miss();
      do_look(30'h0BAD_F00D, 13'h123, 1'b0);
      check("R3 miss_req", 64'(o_miss), 1);
      check("R3 miss_vpn", 64'(o_mvpn), 64'(30'h0BAD_F00D));
      check("R2 paddr zero on miss", 64'(o_pa), 0);
      do_look(30'h2345_6789, 13'h0, 1'b0);
      check("R3 miss_vpn held", 64'(o_mvpn), 64'(30'h0BAD_F00D));
   endtask

   task automatic t_perm();
      do_fill(30'h111, 21'h111, 1'b1, 1'b0, 1'b0);
      do_fill(30'h222, 21'h222, 1'b0, 1'b1, 1'b0);
      do_look(30'h111, 13'h4, 1'b1);
      check("R4 store to read-only faults", 64'({o_fault, o_hit}), 64'(2'b10));
      do_look(30'h111, 13'h4, 1'b0);
      check("R4 load to read-only hits", 64'({o_fault, o_hit}), 64'(2'b01));
      do_look(30'h222, 13'h8, 1'b0);
      check("R4 load to write-only faults", 64'({o_fault, o_hit}), 64'(2'b10));
      check("R4 paddr zero on fault", 64'(o_pa), 0);
      do_look(30'h222, 13'h8, 1'b1);
      check("R4 store to write-only hits", 64'({o_fault, o_hit}), 64'(2'b01));
   endtask

   task automatic t_flush_dup();
      do_fill(30'h333, 21'h333, 1'b1, 1'b1, 1'b1);
      do_look(30'h2345_6789, 13'h0, 1'b0);
      check("R7 flush empties", 64'(o_miss), 1);
      do_look(30'h333, 13'h0, 1'b0);
      check("R7 fill during flush dropped", 64'(o_miss), 1);
      do_fill(30'h777, 21'h0AAAA, 1'b1, 1'b0, 1'b0);
      do_fill(30'h777, 21'h15555, 1'b1, 1'b1, 1'b0);
      do_look(30'h777, 13'h10, 1'b0);
      check("R8 lower slot translation", 64'(o_pa), 64'({21'h0AAAA, 13'h10}));
      do_look(30'h777, 13'h10, 1'b1);
      check("R8 lower slot rights", 64'({o_fault, o_hit}), 64'(2'b10));
      do_fill(30'h0, 21'h0, 1'b0, 1'b0, 1'b1);
   endtask

   task automatic t_replace();
      logic [VPN_W-1:0] res [N];
      int misses, gone;
      for (int k = 0; k < N; k++) begin
         res[k] = VPN_W'(32'h1000 + k);
         do_fill(res[k], PPN_W'(k + 5), 1'b1, 1'b1, 1'b0);
      end
      misses = 0;
      for (int k = 0; k < N; k++) begin
         do_look(res[k], 13'h0, 1'b0);
         if (!o_hit) misses++;
         else check("R5 fill order", 64'(o_pa), 64'({PPN_W'(k + 5), 13'h0}));
      end
      check("R5 no eviction while empty slots", 64'(misses), 0);
      for (int r = 0; r < 8; r++) begin
         int x = (r * 7 + 3) % N;
         logic [VPN_W-1:0] nv = VPN_W'(32'h8000 + r);
         do_look(res[x], 13'h0, 1'b0);
         do_fill(nv, PPN_W'(r + 100), 1'b1, 1'b1, 1'b0);
         do_look(res[x], 13'h0, 1'b0);
         check("R6 recent entry survives", 64'(o_hit), 1);
         misses = 0; gone = 0;
         for (int k = 0; k < N; k++) begin
            do_look(res[k], 13'h0, 1'b0);
            if (!o_hit) begin misses++; gone = k; end
         end
         check("R6 exactly one replaced", 64'(misses), 1);
         do_look(nv, 13'h0, 1'b0);
         check("R6 new entry hits", 64'(o_pa), 64'({PPN_W'(r + 100), 13'h0}));
         if (misses == 1) res[gone] = nv;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_miss();
      t_perm();
      t_flush_dup();
      t_replace();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule